// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block turns an oscillator clock of one of several possible frequencies into a one-cycle tick enable at 1 MHz. Some of those frequencies, such as 19.2 MHz or 38.4 MHz, are not whole multiples of 1 MHz, so a plain integer divider cannot serve them. A 16-bit ratio word holds two fields, both stored as value minus one. The block emits (upper field + 1) ticks for every (lower field + 1) input clocks and spreads them as evenly as the ratio allows. An error accumulator generates them.

Every tick advances a free-running up-counter that software reads as a microsecond time base. Writing a new ratio restarts the accumulator from zero so the new rate starts cleanly, and the counter value is kept across the write.

Top module: `tickdiv_top`

## Requirements
- R1: After reset the ratio word is 0x000b, the tick is low and the counter is zero. With that default ratio, any window of 12·k clocks holds exactly k ticks.
- R2: Bits [7:0] of the ratio word are the clock field C and bits [15:8] are the tick field T. Each field encodes its value plus one. Over the E clocks that follow a write, the tick is high in exactly floor(E·(T+1)/(C+1)) cycles.
- R3: When T+1 < C+1, the distance in clocks between two consecutive ticks is always floor((C+1)/(T+1)) or ceil((C+1)/(T+1)).
- R4: When T+1 ≥ C+1, the tick is high in every clock that is not a write cycle, which caps the rate at one tick per clock.
- R5: A write clears the accumulator. The tick is low in the cycle after the write edge, and counting under the new ratio starts from a zero residue.
- R6: The counter rises by exactly one in the cycle after a tick and holds its value in the cycle after a cycle without a tick.
- R7: A ratio write leaves the counter value unchanged. A tick that is pending at the write edge is still counted.
- R8: The counter wraps modulo 2^CNT_W.
- R9: The ratio words 0x000b, 0x000c, 0x043f, 0x0453, 0x045f, 0x0019, 0x04bf and 0x002f give exactly 1 MHz from 12, 13, 12.8, 16.8, 19.2, 26, 38.4 and 48 MHz inputs respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Ratio word write strobe |
| cfg_wdata | input | 16 | Ratio word: [15:8] tick field, [7:0] clock field |
| tick_o | output | 1 | One-cycle 1 MHz tick enable |
| us_count_o | output | CNT_W | Microsecond counter, counts up |

## Verification
The assertions check four things on every cycle: the counter steps exactly when the tick was high, a write leaves a zero residue and a low tick, the rate is capped when the tick field is not smaller than the clock field, and the residue stays below the clock field. Only the bench scenarios can show the long-run behaviour. They confirm that the tick count over a window matches the floor formula, that tick spacing is even, that the reset default ratio applies, that the counter wraps and that the listed oscillator settings give exactly 1 MHz. The bench sweeps every pair of field values from 0 to 15 as well as the named settings.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam int RATE_W  = FIELD_W + 1;
  localparam int ACC_W   = FIELD_W + 2;

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [ACC_W-1:0]  acc_t;

  typedef struct packed {
    logic [FIELD_W-1:0] ticks_m1;
    logic [FIELD_W-1:0] clks_m1;
  } ratio_t;

  // n+1 decode of a stored field
  function automatic rate_t plus_one(logic [FIELD_W-1:0] f);
    return rate_t'({1'b0, f}) + rate_t'(1);
  endfunction

  // rate saturates at one tick per clock
  function automatic logic is_capped(rate_t num, rate_t den);
    return num >= den;
  endfunction
endpackage

// File: rtl/tickdiv_ratio_reg.sv
module tickdiv_ratio_reg
  import tickdiv_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h000b
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output rate_t            num,
  output rate_t            den
);
  ratio_t ratio_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ratio_q <= ratio_t'(CFG_RESET);
    else if (we) ratio_q <= ratio_t'(wdata);
  end

  assign num = plus_one(ratio_q.ticks_m1);
  assign den = plus_one(ratio_q.clks_m1);
endmodule

// File: rtl/tickdiv_accum.sv
module tickdiv_accum
  import tickdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  rate_t num,
  input  rate_t den,
  output logic  tick,
  output acc_t  acc,
  output logic  capped
);
  acc_t sum;
  acc_t acc_nxt;
  logic hit;

  always_comb begin
    capped  = is_capped(num, den);
    sum     = acc + acc_t'(num);
    hit     = capped || (sum >= acc_t'(den));
    if (capped)   acc_nxt = '0;
    else if (hit) acc_nxt = sum - acc_t'(den);
    else          acc_nxt = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_nxt;
      tick <= hit;
    end
  end
endmodule

// File: rtl/tickdiv_counter.sv
module tickdiv_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/tickdiv_top.sv
module tickdiv_top
  import tickdiv_pkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h000b
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             tick_o,
  output logic [CNT_W-1:0] us_count_o
);
  rate_t num_w;
  rate_t den_w;
  acc_t  acc_w;
  logic  cap_w;
  logic  tick_w;

  tickdiv_ratio_reg #(.CFG_RESET(CFG_RESET)) u_ratio (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .num(num_w), .den(den_w)
  );

  tickdiv_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we), .num(num_w), .den(den_w),
    .tick(tick_w), .acc(acc_w), .capped(cap_w)
  );

  tickdiv_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(tick_w), .count(us_count_o)
  );

  assign tick_o = tick_w;
endmodule

// File: rtl/tickdiv_chk.sv
module tickdiv_chk
  import tickdiv_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input acc_t             acc,
  input rate_t            num,
  input rate_t            den
);
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + CNT_W'(1));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R5
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (acc == '0 && !tick));

  // R4
  rate_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (num >= den && !cfg_we) |=> tick);

  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (num < den) |-> (acc < acc_t'(den)));
endmodule

bind tickdiv_top tickdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tick(tick_w),
  .count(us_count_o), .acc(acc_w), .num(num_w), .den(den_w)
);

// File: tb/tickdiv_top_tb.sv
module tickdiv_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        tick;
  logic [31:0] cnt;
  logic        tick_s;
  logic [7:0]  cnt_s;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tickdiv_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick_o(tick), .us_count_o(cnt)
  );

  // narrow counter, ratio 1:1 out of reset, for the wrap check
  tickdiv_top #(.CNT_W(8), .CFG_RESET(16'h0000)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_wdata(16'h0000),
    .tick_o(tick_s), .us_count_o(cnt_s)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // write a ratio word, then watch E clocks
  task automatic measure(logic [15:0] w, int e);
    int num = int'(w[15:8]) + 1;
    int den = int'(w[7:0]) + 1;
    int exp_t = (e * num) / den;
    int got = 0, last = 0, bad_gap = 0, gmin, gmax;
    logic [31:0] c_pre, c_w;
    logic t_pre;
    if (exp_t > e) exp_t = e;
    gmin = den / num;
    gmax = (den + num - 1) / num;
    @(negedge clk);
    c_pre = cnt; t_pre = tick;
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    c_w = cnt;
    check(tick == 1'b0, "R5", "tick after write", longint'(tick), 0);
    check(c_w == c_pre + 32'(t_pre), "R7", "count across write",
          longint'(c_w), longint'(c_pre + 32'(t_pre)));
    for (int j = 1; j <= e; j++) begin
      @(negedge clk);
      if (tick) begin
        got++;
        if (num < den && last > 0 && bad_gap == 0 &&
            ((j - last) < gmin || (j - last) > gmax))
          bad_gap = j - last;
        last = j;
      end
    end
    @(negedge clk);
    if (num >= den) check(got == exp_t, "R4", "capped tick count", got, exp_t);
    else            check(got == exp_t, "R2", "tick count", got, exp_t);
    check(cnt - c_w == 32'(got), "R6", "counter delta", longint'(cnt - c_w), got);
    if (num < den)
      check(bad_gap == 0, "R3", "tick gap", bad_gap, gmin);
  endtask

  // named oscillator settings: word, input kHz
  task automatic named(logic [15:0] w, int khz);
    int num = int'(w[15:8]) + 1;
    int den = int'(w[7:0]) + 1;
    check(khz * num == den * 1000, "R9", "ratio yields 1 MHz", khz * num, den * 1000);
    measure(w, den * 10);
  endtask

  initial begin
    logic [31:0] c0;
    logic [7:0]  s0;
    int t;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1", "tick in reset", longint'(tick), 0);
    check(cnt == 32'd0, "R1", "count in reset", longint'(cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cnt == 32'd0, "R1", "count after release", longint'(cnt), 0);
    repeat (30) @(negedge clk);
    t = 0; c0 = cnt;
    for (int j = 0; j < 240; j++) begin
      @(negedge clk);
      if (tick) t++;
    end
    check(t == 20, "R1", "default ratio ticks per 240", t, 20);

    // R8 wrap on the narrow counter (one tick per clock)
    s0 = cnt_s;
    repeat (256) @(negedge clk);
    check(cnt_s == s0, "R8", "wrap after 256 ticks", longint'(cnt_s), longint'(s0));
    repeat (100) @(negedge clk);
    check(cnt_s == s0 + 8'd100, "R8", "count mod 256", longint'(cnt_s),
          longint'(s0 + 8'd100));

    named(16'h000b, 12000);
    named(16'h000c, 13000);
    named(16'h043f, 12800);
    named(16'h0453, 16800);
    named(16'h045f, 19200);
    named(16'h0019, 26000);
    named(16'h04bf, 38400);
    named(16'h002f, 48000);

    // sweep of small field values, including capped ratios
    for (int c = 0; c < 16; c++)
      for (int d = 0; d < 16; d++)
        measure({4'd0, 4'(d), 4'd0, 4'(c)}, 48);

    // far-apart fields: slowest and fastest ratios
    measure(16'h00ff, 600);
    measure(16'hff00, 40);
    measure(16'h7fff, 600);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule